// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block frees an I2C bus after a target device has been left holding SDA low by an interrupted transfer. An external controller decides that recovery is needed and raises a start request. The sequencer then drives a fixed burst of clock pulses on SCL while leaving SDA released. To the stuck device, the released SDA reads as a not-acknowledge. The burst lets the device finish shifting out whatever byte it was in the middle of.

After the burst the sequencer forms a proper STOP condition, so every device on the bus returns to idle. It then reports completion with a single-cycle pulse.

Both bus lines are handled as open-drain. Each output is an enable that, when high, pulls its line low; when the enable is low, the line is released to its pull-up. Every phase has the same dwell time. That time is the product of a clock-cycles-per-microsecond parameter and a phase length in microseconds, 20 µs by default. The number of pulses defaults to nine.

Top module: `i2c_bus_clear`

## Requirements
- R1: While reset is high, and on the first cycle after any clock edge that samples reset high, `scl_oe`, `sda_oe`, `busy` and `done` are all 0. A reset applied in the middle of a run returns the block to idle.
- R2: When `start` is sampled high while `busy` is 0, the following cycle shows `busy`=1, `scl_oe`=1 and `sda_oe`=0.
- R3: A run drives exactly NUM_PULSES low pulses on `scl_oe` (9 by default) before the STOP part begins. Counting the STOP preparation low phase, `scl_oe` rises NUM_PULSES+1 times per run.
- R4: Each clock pulse is a low phase (`scl_oe`=1) followed by a high phase (`scl_oe`=0). Every phase lasts exactly PHASE_US×CYC_PER_US clock cycles, written P below.
- R5: `sda_oe` stays 0 for the whole pulse train, which covers the first 2×NUM_PULSES×P cycles of a run.
- R6: After the pulse train, one phase has `scl_oe`=1 and `sda_oe`=1. A second phase follows with `scl_oe`=0 and `sda_oe`=1, which is the STOP setup. Then `sda_oe` returns to 0 while `scl_oe` stays 0. SDA changes only while SCL is driven low, except at the final release.
- R7: `done` is high for exactly one cycle. That cycle is the one in which `sda_oe` is released and `busy` falls, 2×(NUM_PULSES+1)×P cycles after the first busy cycle.
- R8: `busy` stays high from the cycle after the accepted start until the `done` cycle. A `start` sampled while `busy` is 1 leaves the waveform unchanged.
- R9: A `start` presented during the `done` cycle is accepted. The next run begins on the following cycle with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Recovery request, sampled on each rising edge |
| scl_oe | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| busy | output | 1 | High while a recovery run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |

## Verification
The end of one run and the acceptance of the next can fall in the same cycle. `busy` has already dropped while `done` is still high, so a `start` present in that cycle must open a new run at once. The bench provokes this by raising `start` exactly in the `done` cycle of one run. It then checks the following run cycle by cycle from its very first cycle. The bench also places a `start` on the last cycle of the STOP setup, where the request must still be ignored. That placement separates the accepting edge from the one just before it.

// File: rtl/i2c_bus_clear_pkg.sv
package i2c_bus_clear_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_CLK_LOW    = 3'd1,
    ST_CLK_HIGH   = 3'd2,
    ST_STOP_LOW   = 3'd3,
    ST_STOP_SETUP = 3'd4
  } bc_state_t;

  function automatic int unsigned width_for(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bc_phase_timer.sv
module bc_phase_timer #(
  parameter int unsigned PHASE_CYC = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expire
);
  localparam int unsigned TW = i2c_bus_clear_pkg::width_for(PHASE_CYC);
  localparam logic [TW-1:0] RELOAD = TW'(PHASE_CYC - 1);

  logic [TW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= RELOAD;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expire = (remain_q == '0);
endmodule

// File: rtl/bc_pulse_counter.sv
module bc_pulse_counter #(
  parameter int unsigned NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int unsigned CW = i2c_bus_clear_pkg::width_for(NUM_PULSES);
  localparam logic [CW-1:0] FINAL = CW'(NUM_PULSES - 1);

  logic [CW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count_q <= '0;
    end else if (step) begin
      count_q <= count_q + 1'b1;
    end
  end

  assign last = (count_q == FINAL);
endmodule

// File: rtl/bc_sequencer.sv
module bc_sequencer
  import i2c_bus_clear_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic phase_expire,
  input  logic pulse_last,
  output logic timer_load,
  output logic count_clear,
  output logic count_step,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);
  bc_state_t state_q, state_n;
  logic      finish_n;

  always_comb begin
    state_n     = state_q;
    timer_load  = 1'b0;
    count_clear = 1'b0;
    count_step  = 1'b0;
    finish_n    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_n     = ST_CLK_LOW;
          timer_load  = 1'b1;
          count_clear = 1'b1;
        end
      end
      ST_CLK_LOW: begin
        if (phase_expire) begin
          state_n    = ST_CLK_HIGH;
          timer_load = 1'b1;
        end
      end
      ST_CLK_HIGH: begin
        if (phase_expire) begin
          timer_load = 1'b1;
          if (pulse_last) begin
            state_n = ST_STOP_LOW;
          end else begin
            state_n    = ST_CLK_LOW;
            count_step = 1'b1;
          end
        end
      end
      ST_STOP_LOW: begin
        if (phase_expire) begin
          state_n    = ST_STOP_SETUP;
          timer_load = 1'b1;
        end
      end
      ST_STOP_SETUP: begin
        if (phase_expire) begin
          state_n  = ST_IDLE;
          finish_n = 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      scl_oe  <= (state_n == ST_CLK_LOW) || (state_n == ST_STOP_LOW);
      sda_oe  <= (state_n == ST_STOP_LOW) || (state_n == ST_STOP_SETUP);
      busy    <= (state_n != ST_IDLE);
      done    <= finish_n;
    end
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear #(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned PHASE_US   = 20,
  parameter int unsigned NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic scl_oe,
  output logic sda_oe,
  output logic busy,
  output logic done
);
  localparam int unsigned PHASE_CYC = CYC_PER_US * PHASE_US;

  logic timer_load, phase_expire;
  logic count_clear, count_step, pulse_last;

  bc_phase_timer #(.PHASE_CYC(PHASE_CYC)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .load   (timer_load),
    .expire (phase_expire)
  );

  bc_pulse_counter #(.NUM_PULSES(NUM_PULSES)) count_i (
    .clk   (clk),
    .rst   (rst),
    .clear (count_clear),
    .step  (count_step),
    .last  (pulse_last)
  );

  bc_sequencer seq_i (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .phase_expire (phase_expire),
    .pulse_last   (pulse_last),
    .timer_load   (timer_load),
    .count_clear  (count_clear),
    .count_step   (count_step),
    .scl_oe       (scl_oe),
    .sda_oe       (sda_oe),
    .busy         (busy),
    .done         (done)
  );
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
  parameter int unsigned PHASE_CYC  = 40,
  parameter int unsigned NUM_PULSES = 9
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic done
);
  logic        scl_prev, busy_prev;
  logic [31:0] run_len;
  logic [15:0] rise_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev  <= 1'b0;
      busy_prev <= 1'b0;
      run_len   <= 32'd1;
      rise_cnt  <= '0;
    end else begin
      scl_prev  <= scl_oe;
      busy_prev <= busy;
      if (scl_oe != scl_prev) run_len <= 32'd1;
      else if (run_len != 32'hFFFF_FFFF) run_len <= run_len + 32'd1;
      if (done) rise_cnt <= '0;
      else if (scl_oe && !scl_prev) rise_cnt <= rise_cnt + 16'd1;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!scl_oe && !sda_oe && !busy && !done));

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && scl_oe && !sda_oe));

  assert_pulse_count_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (rise_cnt == 16'(NUM_PULSES + 1)));

  assert_phase_len_R4: assert property (@(posedge clk) disable iff (rst)
    ((scl_oe != scl_prev) && busy_prev) |-> (run_len == 32'(PHASE_CYC)));

  assert_sda_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> scl_oe);

  assert_sda_release_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe) |-> !scl_oe);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_release_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !sda_oe && !scl_oe && busy_prev));

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));
endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(
  .PHASE_CYC  (PHASE_CYC),
  .NUM_PULSES (NUM_PULSES)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .scl_oe (scl_oe),
  .sda_oe (sda_oe),
  .busy   (busy),
  .done   (done)
);

// File: tb/i2c_bus_clear_tb_top.sv
`timescale 1ns/1ps
module i2c_bus_clear_tb_top;
  localparam int CPU   = 2;
  localparam int PUS   = 20;
  localparam int NP    = 9;
  localparam int P     = CPU * PUS;
  localparam int TRAIN = 2 * NP * P;
  localparam int RUN   = 2 * (NP + 1) * P;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic scl_oe, sda_oe, busy, done;
  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;

  always #5 clk = ~clk;

  i2c_bus_clear #(.CYC_PER_US(CPU), .PHASE_US(PUS), .NUM_PULSES(NP)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Begins at the negedge of run cycle 0 (start already accepted).
  task automatic measure(input bit chain, input int poke1, input int poke2);
    int   bad_scl = 0, bad_sda_train = 0, bad_sda_stop = 0;
    int   bad_busy = 0, bad_done = 0;
    int   rise_train = 0, rise_all = 0;
    logic prev = 1'b0;
    chk(busy && scl_oe && !sda_oe && !done, "R2", "first run cycle {busy,scl,sda,done}",
        {busy, scl_oe, sda_oe, done}, 4'b1100);
    for (int k = 0; k <= RUN; k++) begin
      logic e_scl, e_sda, e_busy, e_done;
      if (k < TRAIN) e_scl = ((k / P) % 2) == 0;
      else           e_scl = (k < TRAIN + P);
      e_sda  = (k >= TRAIN) && (k < RUN);
      e_busy = (k < RUN);
      e_done = (k == RUN);
      if (scl_oe !== e_scl) bad_scl++;
      if (k < TRAIN && sda_oe !== e_sda) bad_sda_train++;
      if (k >= TRAIN && sda_oe !== e_sda) bad_sda_stop++;
      if (busy !== e_busy) bad_busy++;
      if (done !== e_done) bad_done++;
      if (scl_oe && !prev) begin
        rise_all++;
        if (k < TRAIN) rise_train++;
      end
      prev = scl_oe;
      start = (k == poke1) || (k == poke2) || (chain && k == RUN);
      @(negedge clk);
    end
    start = 1'b0;
    chk(rise_train == NP, "R3", "low pulses in train", rise_train, NP);
    chk(rise_all == NP + 1, "R3", "scl_oe rises per run", rise_all, NP + 1);
    chk(bad_scl == 0, "R4", "scl_oe phase mismatches", bad_scl, 0);
    chk(bad_sda_train == 0, "R5", "sda_oe driven during train", bad_sda_train, 0);
    chk(bad_sda_stop == 0, "R6", "stop sequence sda mismatches", bad_sda_stop, 0);
    chk(bad_done == 0, "R7", "done timing mismatches", bad_done, 0);
    chk(bad_busy == 0, "R8", "busy window mismatches", bad_busy, 0);
    if (!chain)
      chk(!done && !busy, "R7", "idle after done {busy,done}", {busy, done}, 0);
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1", "outputs in reset",
        {scl_oe, sda_oe, busy, done}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1", "idle without start",
        {scl_oe, sda_oe, busy, done}, 0);
  endtask

  task automatic t_basic();
    kick();
    measure(1'b0, -1, -1);
  endtask

  task automatic t_start_while_busy_R8();
    kick();
    measure(1'b0, 3, RUN - 1);
  endtask

  task automatic t_back_to_back_R9();
    kick();
    measure(1'b1, -1, -1);
    chk(busy && scl_oe, "R9", "restart from done cycle {busy,scl}", {busy, scl_oe}, 3);
    measure(1'b0, -1, -1);
  endtask

  task automatic t_reset_mid_run();
    kick();
    repeat (P + 7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!scl_oe && !sda_oe && !busy && !done, "R1", "outputs after mid-run reset",
        {scl_oe, sda_oe, busy, done}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "stays idle after reset", busy, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_start_while_busy_R8();
    t_back_to_back_R9();
    t_reset_mid_run();
    t_basic();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule